// File: doc/BRIEF.md
# Capture/Compare Timer with Infrared Carrier Gating

This block is a 16-bit up-counter with five channels. Each channel is either a pulse-width output that compares the count against its own threshold, or a capture input that stores the count when a chosen edge arrives on a pin. A divider in front of the counter slows its advance by 1, 8, 32 or 128. The counter climbs from zero to a programmed limit, then returns to zero.

An 8-bit carrier timer sits beside the main counter. It has its own divider, limit and threshold, and it drives a square-ish carrier waveform. With infrared mode set, the main counter advances once per full carrier cycle instead of on divided clocks. Every pulse-width output is then ANDed with the carrier. The main counter's thresholds set the envelope, so a modulated infrared burst comes out with no software action per bit.

New limit and threshold values take effect at the next wrap while a timer runs. While a timer is stopped they load at once. This prevents runt pulses when software changes settings mid-period.

Top module: `capcmpTimer`

## Requirements
- R1: After reset, count, every channel output, every capture value, every capture flag and the carrier output are all zero.
- R2: prescSel picks the divide ratio of the main counter: 0 gives 1, 1 gives 8, 2 gives 32, 3 gives 128. After N clock edges with enable high, count equals floor(N / ratio), taken modulo (limit + 1).
- R3: The main counter runs from 0 to the active limit, inclusive, then returns to 0 on the next advance. A limit of 0 holds count at 0.
- R4: While enable is low, count holds its value, and the divider restarts from zero when enable next rises.
- R5: A channel in output mode (chCapMode bit 0) drives high while count is below its active threshold and low otherwise. A threshold of 0 keeps the output low. A threshold above the limit keeps it high.
- R6: While the counter runs, writes to periodIn or cmpIn take effect only when count wraps to 0. While enable is low, they load in the following clock.
- R7: A channel in capture mode (chCapMode bit 1) drives its output low. Its 2-bit field in capEdge picks the capturing edge: bit 0 is rising and bit 1 is falling; 11 captures both edges and 00 captures neither. The pin passes through two synchronising flops. The count is stored and the channel's flag set on the third clock edge after the pin changes.
- R8: A capture flag stays set until its capFlagClr bit is high in a cycle with no new capture event for that channel. That cycle clears it.
- R9: With irMode high, the main counter advances exactly once per carrier period, that is, when the carrier count wraps, and ignores prescSel.
- R10: With irMode high, each channel output is its pulse-width value ANDed with carOut.
- R11: The carrier counter runs from 0 to carPeriod after its own divider (carPrescSel, same encoding as R2). carOut is high while the carrier count is below the active carCmp. Carrier limit and threshold follow the load rule of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run both counters; low freezes them and loads settings |
| irMode | input | 1 | Clock main counter from carrier wraps and gate outputs with carrier |
| prescSel | input | 2 | Main divider select (1/8/32/128) |
| periodIn | input | 16 | Main counter limit |
| cmpIn | input | 80 | Five 16-bit thresholds, channel 0 in the low bits |
| chCapMode | input | 5 | Per channel: 1 capture, 0 pulse-width output |
| capEdge | input | 10 | Per channel 2-bit edge select (bit 0 rising, bit 1 falling) |
| capIn | input | 5 | Capture pins, asynchronous |
| capFlagClr | input | 5 | Per channel flag clear |
| carPrescSel | input | 2 | Carrier divider select |
| carPeriod | input | 8 | Carrier limit |
| carCmp | input | 8 | Carrier threshold |
| count | output | 16 | Main counter value |
| chOut | output | 5 | Channel outputs |
| capVal | output | 80 | Five stored capture values |
| capFlag | output | 5 | Capture flags |
| carOut | output | 1 | Carrier waveform |

## Verification
The bench builds the block with its default widths: a 16-bit main counter, five channels and an 8-bit carrier. It drives small limits, so wraps, a zero limit and thresholds above the limit all occur within a few dozen cycles. The slowest divider of 128 still produces several advances inside a few hundred cycles. A carrier limit of 1 to 3 makes the infrared envelope and the carrier gating visible within tens of clocks.

// File: rtl/capcmpPkg.sv
package capcmpPkg;
  localparam int DIV_W = 7;

  typedef struct packed {
    logic tick;
    logic wrap;
    logic load;
  } strobeT;

  function automatic logic [DIV_W-1:0] prescMask(input logic [1:0] sel);
    case (sel)
      2'd0:    return 7'd0;
      2'd1:    return 7'd7;
      2'd2:    return 7'd31;
      default: return 7'd127;
    endcase
  endfunction
endpackage

// File: rtl/tickDivider.sv
module tickDivider
  import capcmpPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] mask;

  assign mask = prescMask(sel);
  assign tick = enable && ((divCnt & mask) == mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (!enable) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end
endmodule

// File: rtl/carrierTimer8.sv
module carrierTimer8 #(
  parameter int CAR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       prescSel,
  input  logic [CAR_W-1:0] period,
  input  logic [CAR_W-1:0] cmp,
  output logic             carOut,
  output logic             carWrap
);
  logic             carTick;
  logic             carLoad;
  logic [CAR_W-1:0] carCnt;
  logic [CAR_W-1:0] perAct;
  logic [CAR_W-1:0] cmpAct;

  tickDivider u_div (
    .clk(clk), .rstN(rstN), .enable(enable), .sel(prescSel), .tick(carTick)
  );

  assign carWrap = carTick && (carCnt >= perAct);
  assign carLoad = carWrap || !enable;
  assign carOut  = carCnt < cmpAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carCnt <= '0;
      perAct <= '0;
      cmpAct <= '0;
    end else begin
      if (carWrap)      carCnt <= '0;
      else if (carTick) carCnt <= carCnt + 1'b1;
      if (carLoad) begin
        perAct <= period;
        cmpAct <= cmp;
      end
    end
  end
endmodule

// File: rtl/capcmpCtrl.sv
module capcmpCtrl
  import capcmpPkg::*;
#(
  parameter int NUM_CH = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                irMode,
  input  logic [1:0]          prescSel,
  input  logic                carWrap,
  input  logic                atPeriod,
  input  logic [NUM_CH-1:0]   capIn,
  input  logic [NUM_CH-1:0]   chCapMode,
  input  logic [2*NUM_CH-1:0] capEdge,
  output strobeT              strb,
  output logic [NUM_CH-1:0]   capEv
);
  logic presTick;

  tickDivider u_div (
    .clk(clk), .rstN(rstN), .enable(enable), .sel(prescSel), .tick(presTick)
  );

  always_comb begin
    strb.tick = enable && (irMode ? carWrap : presTick);
    strb.wrap = strb.tick && atPeriod;
    strb.load = strb.wrap || !enable;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sync
    logic syncA, syncB, syncPrev;
    logic riseSeen, fallSeen;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA    <= 1'b0;
        syncB    <= 1'b0;
        syncPrev <= 1'b0;
      end else begin
        syncA    <= capIn[i];
        syncB    <= syncA;
        syncPrev <= syncB;
      end
    end

    assign riseSeen = syncB && !syncPrev;
    assign fallSeen = !syncB && syncPrev;
    assign capEv[i] = chCapMode[i] &&
                      ((capEdge[2*i] && riseSeen) || (capEdge[2*i+1] && fallSeen));
  end
endmodule

// File: rtl/capcmpDatapath.sv
module capcmpDatapath
  import capcmpPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  strb,
  input  logic [CNT_W-1:0]        periodIn,
  input  logic [NUM_CH*CNT_W-1:0] cmpIn,
  input  logic [NUM_CH-1:0]       chCapMode,
  input  logic                    irMode,
  input  logic                    carOut,
  input  logic [NUM_CH-1:0]       capEv,
  input  logic [NUM_CH-1:0]       capFlagClr,
  output logic [CNT_W-1:0]        count,
  output logic                    atPeriod,
  output logic [NUM_CH-1:0]       chOut,
  output logic [NUM_CH*CNT_W-1:0] capVal,
  output logic [NUM_CH-1:0]       capFlag
);
  logic [CNT_W-1:0] periodAct;

  assign atPeriod = count >= periodAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      periodAct <= '0;
    end else begin
      if (strb.wrap)      count <= '0;
      else if (strb.tick) count <= count + 1'b1;
      if (strb.load)      periodAct <= periodIn;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CNT_W-1:0] cmpAct;
    logic [CNT_W-1:0] capReg;
    logic             flagReg;
    logic             pwmLvl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpAct  <= '0;
        capReg  <= '0;
        flagReg <= 1'b0;
      end else begin
        if (strb.load) cmpAct <= cmpIn[i*CNT_W +: CNT_W];
        if (capEv[i]) begin
          capReg  <= count;
          flagReg <= 1'b1;
        end else if (capFlagClr[i]) begin
          flagReg <= 1'b0;
        end
      end
    end

    assign pwmLvl   = count < cmpAct;
    assign chOut[i] = !chCapMode[i] && pwmLvl && (!irMode || carOut);
    assign capVal[i*CNT_W +: CNT_W] = capReg;
    assign capFlag[i] = flagReg;
  end
endmodule

// File: rtl/capcmpTimer.sv
module capcmpTimer
  import capcmpPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 5,
  parameter int CAR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    irMode,
  input  logic [1:0]              prescSel,
  input  logic [CNT_W-1:0]        periodIn,
  input  logic [NUM_CH*CNT_W-1:0] cmpIn,
  input  logic [NUM_CH-1:0]       chCapMode,
  input  logic [2*NUM_CH-1:0]     capEdge,
  input  logic [NUM_CH-1:0]       capIn,
  input  logic [NUM_CH-1:0]       capFlagClr,
  input  logic [1:0]              carPrescSel,
  input  logic [CAR_W-1:0]        carPeriod,
  input  logic [CAR_W-1:0]        carCmp,
  output logic [CNT_W-1:0]        count,
  output logic [NUM_CH-1:0]       chOut,
  output logic [NUM_CH*CNT_W-1:0] capVal,
  output logic [NUM_CH-1:0]       capFlag,
  output logic                    carOut
);
  strobeT            strb;
  logic              carWrap;
  logic              atPeriod;
  logic [NUM_CH-1:0] capEv;

  carrierTimer8 #(.CAR_W(CAR_W)) u_car (
    .clk(clk), .rstN(rstN), .enable(enable), .prescSel(carPrescSel),
    .period(carPeriod), .cmp(carCmp), .carOut(carOut), .carWrap(carWrap)
  );

  capcmpCtrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .irMode(irMode),
    .prescSel(prescSel), .carWrap(carWrap), .atPeriod(atPeriod),
    .capIn(capIn), .chCapMode(chCapMode), .capEdge(capEdge),
    .strb(strb), .capEv(capEv)
  );

  capcmpDatapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .periodIn(periodIn), .cmpIn(cmpIn),
    .chCapMode(chCapMode), .irMode(irMode), .carOut(carOut), .capEv(capEv),
    .capFlagClr(capFlagClr), .count(count), .atPeriod(atPeriod),
    .chOut(chOut), .capVal(capVal), .capFlag(capFlag)
  );
endmodule

// File: rtl/capcmpTimerChk.sv
module capcmpTimerChk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              irMode,
  input logic [1:0]        prescSel,
  input logic [NUM_CH-1:0] chCapMode,
  input logic [NUM_CH-1:0] capFlagClr,
  input logic [CNT_W-1:0]  count,
  input logic [NUM_CH-1:0] chOut,
  input logic [NUM_CH-1:0] capFlag,
  input logic              carOut
);
  assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(count));

  assert_step_or_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !irMode && prescSel == 2'd0) |=>
      ((count == $past(count) + 1'b1) || (count == '0)));

  assert_capture_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (chOut & chCapMode) == '0);

  assert_ir_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irMode && !carOut) |-> (chOut == '0));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((capFlag & $past(capFlag & ~capFlagClr)) == $past(capFlag & ~capFlagClr)));
endmodule

bind capcmpTimer capcmpTimerChk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .irMode(irMode), .prescSel(prescSel),
  .chCapMode(chCapMode), .capFlagClr(capFlagClr), .count(count), .chOut(chOut),
  .capFlag(capFlag), .carOut(carOut)
);

// File: tb/capcmpTimer_bench.sv
module capcmpTimer_bench;
  localparam int CNT_W = 16;
  localparam int NUM_CH = 5;
  localparam int CAR_W = 8;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    enable = 1'b0;
  logic                    irMode = 1'b0;
  logic [1:0]              prescSel = '0;
  logic [CNT_W-1:0]        periodIn = '0;
  logic [NUM_CH*CNT_W-1:0] cmpIn = '0;
  logic [NUM_CH-1:0]       chCapMode = '0;
  logic [2*NUM_CH-1:0]     capEdge = '0;
  logic [NUM_CH-1:0]       capIn = '0;
  logic [NUM_CH-1:0]       capFlagClr = '0;
  logic [1:0]              carPrescSel = '0;
  logic [CAR_W-1:0]        carPeriod = '0;
  logic [CAR_W-1:0]        carCmp = '0;
  logic [CNT_W-1:0]        count;
  logic [NUM_CH-1:0]       chOut;
  logic [NUM_CH*CNT_W-1:0] capVal;
  logic [NUM_CH-1:0]       capFlag;
  logic                    carOut;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  capcmpTimer #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .CAR_W(CAR_W)) u_capcmpTimer (
    .clk(clk), .rstN(rstN), .enable(enable), .irMode(irMode), .prescSel(prescSel),
    .periodIn(periodIn), .cmpIn(cmpIn), .chCapMode(chCapMode), .capEdge(capEdge),
    .capIn(capIn), .capFlagClr(capFlagClr), .carPrescSel(carPrescSel),
    .carPeriod(carPeriod), .carCmp(carCmp), .count(count), .chOut(chOut),
    .capVal(capVal), .capFlag(capFlag), .carOut(carOut)
  );

  // presc, period, cmp0, edges, expected count, expected chOut[0]
  localparam int VEC [0:6][0:5] = '{
    '{0, 100,   20,  10, 10, 1},
    '{0,   5,    2,  14,  2, 0},
    '{1, 100,    0,  20,  2, 0},
    '{2, 100,    3,  70,  2, 1},
    '{3, 1000, 2000, 300, 2, 1},
    '{0,   0,    1,   7,  0, 1},
    '{1,   3,    1,  40,  1, 0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startRun(input int ps, input int per, input int c0, input int ir,
                          input int cps, input int cper, input int ccmp);
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; capFlagClr = '0; chCapMode = '0; capEdge = '0;
    capIn = '0;
    prescSel = ps[1:0]; periodIn = per[CNT_W-1:0]; cmpIn = '0;
    cmpIn[CNT_W-1:0] = c0[CNT_W-1:0]; irMode = ir[0];
    carPrescSel = cps[1:0]; carPeriod = cper[CAR_W-1:0]; carCmp = ccmp[CAR_W-1:0];
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 count", int'(count), 0);
    check("R1 chOut", int'(chOut), 0);
    check("R1 capFlag", int'(capFlag), 0);
    check("R1 capVal", int'(capVal != '0), 0);
    check("R1 carOut", int'(carOut), 0);

    // R2 R3 R5 vector walk
    for (int v = 0; v < 7; v++) begin
      startRun(VEC[v][0], VEC[v][1], VEC[v][2], 0, 0, 0, 0);
      edges(VEC[v][3]);
      check($sformatf("R2/R3 vec%0d count", v), int'(count), VEC[v][4]);
      check($sformatf("R5 vec%0d chOut0", v), int'(chOut[0]), VEC[v][5]);
    end

    // R6 shadowed limit and threshold
    startRun(0, 20, 10, 0, 0, 0, 0);
    edges(5);
    periodIn = 16'd3;
    cmpIn[CNT_W-1:0] = 16'd2;
    edges(1);
    check("R6 count before wrap", int'(count), 6);
    check("R6 old cmp kept", int'(chOut[0]), 1);
    edges(15);
    check("R6 old period used", int'(count), 0);
    check("R6 new cmp at 0", int'(chOut[0]), 1);
    edges(3);
    check("R6 count 3", int'(count), 3);
    check("R6 new cmp at 3", int'(chOut[0]), 0);
    edges(1);
    check("R6 new period wrap", int'(count), 0);

    // R4 hold while stopped
    startRun(0, 100, 0, 0, 0, 0, 0);
    edges(7);
    enable = 1'b0;
    edges(5);
    check("R4 count held", int'(count), 7);

    // R7 capture on frozen count 7, channel 1
    chCapMode = 5'b00010;
    capEdge = 10'b00_00_00_01_00;
    cmpIn[2*CNT_W-1:CNT_W] = 16'd50;
    edges(1);
    capIn[1] = 1'b1;
    edges(2);
    check("R7 flag not yet", int'(capFlag[1]), 0);
    edges(1);
    check("R7 flag after rise", int'(capFlag[1]), 1);
    check("R7 captured value", int'(capVal[2*CNT_W-1:CNT_W]), 7);
    check("R7 capture mode output low", int'(chOut[1]), 0);

    // R8 clear
    capFlagClr[1] = 1'b1;
    edges(1);
    capFlagClr[1] = 1'b0;
    check("R8 flag cleared", int'(capFlag[1]), 0);

    // R7 falling edge ignored under rising select
    capIn[1] = 1'b0;
    edges(4);
    check("R7 fall ignored", int'(capFlag[1]), 0);
    capEdge[3:2] = 2'b11;
    capIn[1] = 1'b1;
    edges(4);
    check("R7 both: rise", int'(capFlag[1]), 1);
    capFlagClr[1] = 1'b1;
    edges(1);
    capFlagClr[1] = 1'b0;
    capEdge[3:2] = 2'b10;
    capIn[1] = 1'b0;
    edges(4);
    check("R7 falling select", int'(capFlag[1]), 1);
    capFlagClr[1] = 1'b1;
    edges(1);
    capFlagClr[1] = 1'b0;
    capEdge[3:2] = 2'b00;
    capIn[1] = 1'b1;
    edges(4);
    check("R7 none select", int'(capFlag[1]), 0);

    // R9 R10 R11 infrared mode, carrier /1 limit 3 threshold 2
    startRun(3, 100, 3, 1, 0, 3, 2);
    edges(9);
    check("R9 count per carrier", int'(count), 2);
    check("R11 carOut high", int'(carOut), 1);
    check("R10 gated high", int'(chOut[0]), 1);
    edges(1);
    check("R11 carOut low", int'(carOut), 0);
    check("R10 gated low", int'(chOut[0]), 0);
    edges(3);
    check("R9 count 3", int'(count), 3);
    check("R10 envelope off", int'(chOut[0]), 0);

    // R11 carrier divider /8, limit 1
    startRun(0, 100, 3, 1, 1, 1, 1);
    edges(32);
    check("R11 divided carrier count", int'(count), 2);
    check("R11 carOut", int'(carOut), 1);
    check("R10 gated out", int'(chOut[0]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule